// File: doc/BRIEF.md
# Display Panel Control Register Block

This block is the register front end of a colour display controller. A host reaches it over a plain 32-bit word bus (select, write enable, word address, write data). It holds four panel timing words, two frame base addresses, an interrupt enable mask, a raw interrupt status, a clear port and a control word. It also serves an eight-word read-only identification window. From these registers it derives the live panel geometry (active width in pixels and height in lines), an enable flag and a pixel-depth code. The pixel fetch engine consumes these directly.

Raw status bits are set by an external event vector and stay set until software clears them. The interrupt output is raised while any set bit is also enabled in the mask. A build parameter selects a variant in which the mask and control words trade places in the address map, for both reads and writes. Every write pulses a display-invalidate output. Any access that the map does not support raises an error flag and leaves all state untouched.

Top module: `lcd_regif`

## Requirements
- R1: After reset every register reads zero, the interrupt output, enable and depth are 0, the width output reads 16 and the height output reads 1.
- R2: Timing words (word offsets 0 to 3), the upper base (offset 4) and the lower base (offset 5) read back the full 32-bit value last written. Offset 11 returns the upper base and offset 12 returns the lower base.
- R3: With the variant parameter at 0, offset 6 is the interrupt mask and offset 7 is control. With it at 1, offset 6 is control and offset 7 is the mask, for both reads and writes.
- R4: Panel width equals 16 × (timing0 bits [7:2] + 1). The other timing0 bits have no effect on it.
- R5: Panel height equals timing1 bits [9:0] + 1. The other timing1 bits have no effect on it.
- R6: The pixel-depth output is control bits [3:1]. The enable output is 1 only when control bit 0 and control bit 11 are both 1.
- R7: An event bit at 1 sets the matching raw status bit (offset 8) on the next edge. If a clear write hits the same bit in the same cycle, the event wins.
- R8: A write to offset 10 clears each raw status bit whose written bit is 1 and leaves the others.
- R9: Offset 9 reads raw status AND mask. The interrupt output is 1 exactly when that value is non-zero.
- R10: Offsets 0x3F8 to 0x3FF (byte addresses 0xFE0 to 0xFFF) read one identification byte each, zero-extended, with index = offset − 0x3F8. The default tables are 10 11 04 00 0D F0 05 B1 (variant 0) and 11 11 24 00 0D F0 05 B1 (variant 1), listed from index 0.
- R11: The error flag rises with zero read data, and no register changes, for: any access to offsets 13 to 0x3F7; writes to offsets 8, 9, 11, 12 or the identification window; reads of offset 10.
- R12: Every write, decoded or not, gives a one-cycle display-invalidate pulse in the cycle after the access. Reads give none.
- R13: Read data and the error flag appear in the cycle after the access and are zero in any other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_waddr | input | 10 | Word offset (byte address bits [11:2]) |
| bus_wdata | input | 32 | Write data |
| irq_event | input | NIRQ | Status-set event vector |
| bus_rdata | output | 32 | Read data, one cycle after the access |
| bus_err | output | 1 | Unsupported access flag, one cycle after the access |
| irq_out | output | 1 | OR of enabled status bits |
| disp_invalidate | output | 1 | One-cycle pulse after any write |
| disp_enable | output | 1 | Enable AND power control bits |
| pix_depth | output | 3 | Pixel-depth code |
| panel_width | output | 11 | Active width in pixels |
| panel_height | output | 11 | Active height in lines |

## Verification
The hardest case to reach from the ports is the collision of an external event with a clear write on the same status bit in the same cycle. The bench raises the event vector in the exact cycle in which it drives the clear write, and then reads the raw status to show that the new event survived. The swapped map can only be seen through a second instance built with the variant parameter set. The bench drives both instances and checks that a control value written to one offset moves the enable output on one build and lands in the mask on the other. The geometry and decode rules are swept exhaustively: all 64 width codes and all 1024 word offsets, with the expected error pattern computed from the map rules.

// File: rtl/lcdr_pkg.sv
package lcdr_pkg;

    localparam int WORD_W  = 32;
    localparam int WADDR_W = 10;
    localparam int ID_LEN  = 8;
    localparam logic [WADDR_W-1:0] ID_WORD0 = 10'h3F8;

    typedef enum logic [3:0] {
        SEL_TIM,
        SEL_UPB,
        SEL_LPB,
        SEL_MASK,
        SEL_CTRL,
        SEL_RIS,
        SEL_MIS,
        SEL_ICR,
        SEL_UPCUR,
        SEL_LPCUR,
        SEL_ID,
        SEL_NONE
    } reg_sel_e;

endpackage

// File: rtl/lcdr_decode.sv
module lcdr_decode
    import lcdr_pkg::*;
#(
    parameter bit SWAP_MASK_CTRL = 1'b0
) (
    input  logic [WADDR_W-1:0] waddr,
    output reg_sel_e           sel,
    output logic [1:0]         tim_idx,
    output logic [2:0]         id_idx,
    output logic               rd_ok,
    output logic               wr_ok
);

    reg_sel_e slot6;
    reg_sel_e slot7;

    generate
        if (SWAP_MASK_CTRL) begin : g_swapped
            assign slot6 = SEL_CTRL;
            assign slot7 = SEL_MASK;
        end else begin : g_plain
            assign slot6 = SEL_MASK;
            assign slot7 = SEL_CTRL;
        end
    endgenerate

    always_comb begin
        case (waddr)
            10'd0, 10'd1, 10'd2, 10'd3: sel = SEL_TIM;
            10'd4:  sel = SEL_UPB;
            10'd5:  sel = SEL_LPB;
            10'd6:  sel = slot6;
            10'd7:  sel = slot7;
            10'd8:  sel = SEL_RIS;
            10'd9:  sel = SEL_MIS;
            10'd10: sel = SEL_ICR;
            10'd11: sel = SEL_UPCUR;
            10'd12: sel = SEL_LPCUR;
            default: sel = (waddr >= ID_WORD0) ? SEL_ID : SEL_NONE;
        endcase
    end

    assign tim_idx = waddr[1:0];
    assign id_idx  = waddr[2:0];

    always_comb begin
        rd_ok = (sel != SEL_NONE) && (sel != SEL_ICR);
        case (sel)
            SEL_TIM, SEL_UPB, SEL_LPB, SEL_MASK, SEL_CTRL, SEL_ICR: wr_ok = 1'b1;
            default: wr_ok = 1'b0;
        endcase
    end

endmodule

// File: rtl/lcdr_geom.sv
module lcdr_geom #(
    parameter int PPL_W = 6,
    parameter int LPP_W = 10,
    parameter int GEO_W = 11
) (
    input  logic [PPL_W-1:0] ppl_code,
    input  logic [LPP_W-1:0] lpp_code,
    output logic [GEO_W-1:0] width_px,
    output logic [GEO_W-1:0] height_ln
);

    localparam int PX_PER_UNIT_LOG2 = 4;

    logic [GEO_W-1:0] units;

    always_comb begin
        units     = GEO_W'(ppl_code) + GEO_W'(1);
        width_px  = units << PX_PER_UNIT_LOG2;
        height_ln = GEO_W'(lpp_code) + GEO_W'(1);
    end

endmodule

// File: rtl/lcdr_idrom.sv
module lcdr_idrom
    import lcdr_pkg::*;
#(
    parameter bit          SWAP_MASK_CTRL = 1'b0,
    parameter logic [63:0] TABLE_BASE     = 64'hB105_F00D_0004_1110,
    parameter logic [63:0] TABLE_ALT      = 64'hB105_F00D_0024_1111
) (
    input  logic [$clog2(ID_LEN)-1:0] idx,
    output logic [7:0]                id_byte
);

    logic [63:0] table_sel;

    generate
        if (SWAP_MASK_CTRL) begin : g_alt
            assign table_sel = TABLE_ALT;
        end else begin : g_base
            assign table_sel = TABLE_BASE;
        end
    endgenerate

    assign id_byte = table_sel[idx*8 +: 8];

endmodule

// File: rtl/lcd_regif.sv
module lcd_regif
    import lcdr_pkg::*;
#(
    parameter int          NIRQ           = 5,
    parameter int          CTRL_W         = 16,
    parameter bit          SWAP_MASK_CTRL = 1'b0,
    parameter logic [63:0] ID_TABLE_BASE  = 64'hB105_F00D_0004_1110,
    parameter logic [63:0] ID_TABLE_ALT   = 64'hB105_F00D_0024_1111
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_we,
    input  logic [9:0]         bus_waddr,
    input  logic [31:0]        bus_wdata,
    input  logic [NIRQ-1:0]    irq_event,
    output logic [31:0]        bus_rdata,
    output logic               bus_err,
    output logic               irq_out,
    output logic               disp_invalidate,
    output logic               disp_enable,
    output logic [2:0]         pix_depth,
    output logic [10:0]        panel_width,
    output logic [10:0]        panel_height
);

    localparam int GEO_W    = 11;
    localparam int EN_BIT   = 0;
    localparam int PWR_BIT  = 11;
    localparam int DEPTH_LO = 1;
    localparam int N_TIM    = 4;

    typedef struct packed {
        logic [N_TIM-1:0][WORD_W-1:0] timing;
        logic [WORD_W-1:0]            upbase;
        logic [WORD_W-1:0]            lpbase;
        logic [NIRQ-1:0]              mask;
        logic [NIRQ-1:0]              status;
        logic [CTRL_W-1:0]            ctrl;
        logic [WORD_W-1:0]            rdata;
        logic                         err;
        logic                         inval;
    } state_t;

    state_t q, d;

    reg_sel_e    sel;
    logic [1:0]  tim_idx;
    logic [2:0]  id_idx;
    logic        rd_ok;
    logic        wr_ok;
    logic [7:0]  id_byte;
    logic [NIRQ-1:0]   clr_bits;
    logic [WORD_W-1:0] rd_mux;

    lcdr_decode #(
        .SWAP_MASK_CTRL(SWAP_MASK_CTRL)
    ) u_decode (
        .waddr  (bus_waddr),
        .sel    (sel),
        .tim_idx(tim_idx),
        .id_idx (id_idx),
        .rd_ok  (rd_ok),
        .wr_ok  (wr_ok)
    );

    lcdr_idrom #(
        .SWAP_MASK_CTRL(SWAP_MASK_CTRL),
        .TABLE_BASE    (ID_TABLE_BASE),
        .TABLE_ALT     (ID_TABLE_ALT)
    ) u_idrom (
        .idx    (id_idx),
        .id_byte(id_byte)
    );

    lcdr_geom #(
        .PPL_W(6),
        .LPP_W(10),
        .GEO_W(GEO_W)
    ) u_geom (
        .ppl_code (q.timing[0][7:2]),
        .lpp_code (q.timing[1][9:0]),
        .width_px (panel_width),
        .height_ln(panel_height)
    );

    // read multiplexer
    always_comb begin
        case (sel)
            SEL_TIM:   rd_mux = q.timing[tim_idx];
            SEL_UPB:   rd_mux = q.upbase;
            SEL_LPB:   rd_mux = q.lpbase;
            SEL_MASK:  rd_mux = WORD_W'(q.mask);
            SEL_CTRL:  rd_mux = WORD_W'(q.ctrl);
            SEL_RIS:   rd_mux = WORD_W'(q.status);
            SEL_MIS:   rd_mux = WORD_W'(q.status & q.mask);
            SEL_UPCUR: rd_mux = q.upbase;
            SEL_LPCUR: rd_mux = q.lpbase;
            SEL_ID:    rd_mux = WORD_W'(id_byte);
            default:   rd_mux = '0;
        endcase
    end

    // next-state computation
    always_comb begin
        d       = q;
        d.rdata = '0;
        d.err   = 1'b0;
        d.inval = 1'b0;

        clr_bits = '0;
        if (bus_sel && bus_we && sel == SEL_ICR) begin
            clr_bits = bus_wdata[NIRQ-1:0];
        end
        d.status = (q.status & ~clr_bits) | irq_event;

        if (bus_sel) begin
            if (bus_we) begin
                d.inval = 1'b1;
                if (!wr_ok) begin
                    d.err = 1'b1;
                end else begin
                    case (sel)
                        SEL_TIM:  d.timing[tim_idx] = bus_wdata;
                        SEL_UPB:  d.upbase          = bus_wdata;
                        SEL_LPB:  d.lpbase          = bus_wdata;
                        SEL_MASK: d.mask            = bus_wdata[NIRQ-1:0];
                        SEL_CTRL: d.ctrl            = bus_wdata[CTRL_W-1:0];
                        default:  ;
                    endcase
                end
            end else begin
                if (!rd_ok) begin
                    d.err = 1'b1;
                end else begin
                    d.rdata = rd_mux;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign bus_rdata       = q.rdata;
    assign bus_err         = q.err;
    assign disp_invalidate = q.inval;
    assign irq_out         = |(q.status & q.mask);
    assign disp_enable     = q.ctrl[EN_BIT] & q.ctrl[PWR_BIT];
    assign pix_depth       = q.ctrl[DEPTH_LO +: 3];

    // ---------------- assertions ----------------
    AST_INVAL_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we) |=> disp_invalidate); // R12

    AST_NO_INVAL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && bus_we) |=> !disp_invalidate); // R12

    AST_BAD_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && !wr_ok) |=>
            ($stable(q.timing) && $stable(q.upbase) && $stable(q.lpbase)
             && $stable(q.mask) && $stable(q.ctrl))); // R11

    AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> (bus_rdata == '0)); // R11

    AST_EVENT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_event) |=> ((q.status & $past(irq_event)) == $past(irq_event))); // R7

    AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && sel == SEL_ICR && (&bus_wdata[NIRQ-1:0])
         && irq_event == '0) |=> (q.status == '0)); // R8

    AST_IDLE_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_sel |=> (bus_rdata == '0 && !bus_err)); // R13

    AST_HEIGHT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        panel_height != '0); // R5

endmodule

// File: tb/sim_lcd_regif.sv
module sim_lcd_regif;

    localparam int NIRQ = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_sel = 1'b0;
    logic bus_we = 1'b0;
    logic [9:0] bus_waddr = '0;
    logic [31:0] bus_wdata = '0;
    logic [NIRQ-1:0] irq_event = '0;
    logic which = 1'b0;

    logic [31:0] rdata0, rdata1;
    logic err0, err1, irq0, irq1, inv0, inv1, en0, en1;
    logic [2:0] dep0, dep1;
    logic [10:0] wid0, wid1, hgt0, hgt1;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    lcd_regif #(.NIRQ(NIRQ), .SWAP_MASK_CTRL(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel && !which), .bus_we(bus_we),
        .bus_waddr(bus_waddr), .bus_wdata(bus_wdata), .irq_event(irq_event),
        .bus_rdata(rdata0), .bus_err(err0), .irq_out(irq0), .disp_invalidate(inv0),
        .disp_enable(en0), .pix_depth(dep0), .panel_width(wid0), .panel_height(hgt0));

    lcd_regif #(.NIRQ(NIRQ), .SWAP_MASK_CTRL(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel && which), .bus_we(bus_we),
        .bus_waddr(bus_waddr), .bus_wdata(bus_wdata), .irq_event(irq_event),
        .bus_rdata(rdata1), .bus_err(err1), .irq_out(irq1), .disp_invalidate(inv1),
        .disp_enable(en1), .pix_depth(dep1), .panel_width(wid1), .panel_height(hgt1));

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic do_write(input bit dut, input logic [9:0] a, input logic [31:0] v,
                            output logic e, output logic inv);
        @(negedge clk);
        which = dut; bus_sel = 1'b1; bus_we = 1'b1; bus_waddr = a; bus_wdata = v;
        @(negedge clk);
        e   = dut ? err1 : err0;
        inv = dut ? inv1 : inv0;
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic do_read(input bit dut, input logic [9:0] a,
                           output logic [31:0] v, output logic e);
        @(negedge clk);
        which = dut; bus_sel = 1'b1; bus_we = 1'b0; bus_waddr = a;
        @(negedge clk);
        v = dut ? rdata1 : rdata0;
        e = dut ? err1 : err0;
        bus_sel = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic e, inv;
        logic [31:0] pat [6];
        logic [7:0] id_a [8];
        logic [7:0] id_b [8];
        logic [31:0] t0_last;

        id_a = '{8'h10, 8'h11, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
        id_b = '{8'h11, 8'h11, 8'h24, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
        pat  = '{32'hDEAD_BEEF, 32'h1234_5678, 32'hA5A5_5A5A, 32'h0F0F_F0F0,
                 32'h8000_0001, 32'h7FFF_FFFE};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1", "rdata", rdata0, 0);
        check("R1", "irq", {31'b0, irq0}, 0);
        check("R1", "enable", {31'b0, en0}, 0);
        check("R1", "depth", {29'b0, dep0}, 0);
        check("R1", "width", {21'b0, wid0}, 16);
        check("R1", "height", {21'b0, hgt0}, 1);
        for (int w = 0; w < 13; w++) begin
            if (w == 10) continue;
            do_read(1'b0, w[9:0], v, e);
            check("R1", "reg zero", v, 0);
        end

        // R2 read-back, R12 invalidate pulse, R13 idle data
        for (int w = 0; w < 6; w++) begin
            do_write(1'b0, w[9:0], pat[w], e, inv);
            check("R12", "inval after write", {31'b0, inv}, 1);
            check("R2", "write err", {31'b0, e}, 0);
        end
        for (int w = 0; w < 6; w++) begin
            do_read(1'b0, w[9:0], v, e);
            check("R2", "readback", v, pat[w]);
            check("R12", "no inval on read", {31'b0, inv0}, 0);
        end
        do_read(1'b0, 10'd11, v, e);
        check("R2", "upper current", v, pat[4]);
        do_read(1'b0, 10'd12, v, e);
        check("R2", "lower current", v, pat[5]);
        @(negedge clk);
        check("R13", "idle rdata", rdata0, 0);
        check("R13", "idle err", {31'b0, err0}, 0);

        // R4 width sweep
        for (int p = 0; p < 64; p++) begin
            t0_last = 32'hFFFF_FF00 | (p << 2) | 32'h3;
            do_write(1'b0, 10'd0, t0_last, e, inv);
            check("R4", "width", {21'b0, wid0}, 16 * (p + 1));
        end

        // R5 height
        foreach (pat[i]) begin
            int hv;
            hv = (i == 0) ? 0 : (i == 1) ? 1 : (i == 2) ? 511 : (i == 3) ? 1022 : 1023;
            if (i == 5) hv = 300;
            do_write(1'b0, 10'd1, 32'hFFFF_FC00 | hv, e, inv);
            check("R5", "height", {21'b0, hgt0}, hv + 1);
        end

        // R6 enable and depth
        for (int en = 0; en < 2; en++)
            for (int pw = 0; pw < 2; pw++)
                for (int dp = 0; dp < 8; dp++) begin
                    do_write(1'b0, 10'd7, (pw << 11) | (dp << 1) | en, e, inv);
                    check("R6", "enable", {31'b0, en0}, en & pw);
                    check("R6", "depth", {29'b0, dep0}, dp);
                end

        // R3 map variant
        do_write(1'b0, 10'd7, 32'h0000_0000, e, inv);
        do_write(1'b0, 10'd6, 32'hFFFF_FFF5, e, inv);
        do_read(1'b0, 10'd6, v, e);
        check("R3", "base mask at 6", v, 32'h15);
        check("R3", "base enable untouched", {31'b0, en0}, 0);
        do_write(1'b1, 10'd6, 32'h0000_0801, e, inv);
        check("R3", "alt ctrl at 6", {31'b0, en1}, 1);
        do_write(1'b1, 10'd7, 32'h0000_0003, e, inv);
        do_read(1'b1, 10'd7, v, e);
        check("R3", "alt mask at 7", v, 32'h3);
        do_read(1'b1, 10'd6, v, e);
        check("R3", "alt ctrl read", v, 32'h0801);

        // R7 R8 R9 status handling (u0 mask = 10101)
        @(negedge clk); irq_event = 5'b10011;
        @(negedge clk); irq_event = '0;
        do_read(1'b0, 10'd8, v, e);
        check("R7", "raw set", v, 32'h13);
        do_read(1'b0, 10'd9, v, e);
        check("R9", "masked", v, 32'h11);
        check("R9", "irq high", {31'b0, irq0}, 1);
        do_write(1'b0, 10'd10, 32'h0000_0011, e, inv);
        do_read(1'b0, 10'd8, v, e);
        check("R8", "partial clear", v, 32'h02);
        check("R9", "irq low", {31'b0, irq0}, 0);
        do_read(1'b0, 10'd9, v, e);
        check("R9", "masked zero", v, 0);
        // event and clear on the same bit in the same cycle
        @(negedge clk);
        which = 1'b0; bus_sel = 1'b1; bus_we = 1'b1; bus_waddr = 10'd10;
        bus_wdata = 32'h1F; irq_event = 5'b00100;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0; irq_event = '0;
        do_read(1'b0, 10'd8, v, e);
        check("R7", "event wins over clear", v, 32'h04);
        check("R9", "irq from collision", {31'b0, irq0}, 1);
        do_write(1'b0, 10'd10, 32'h1F, e, inv);
        do_read(1'b0, 10'd8, v, e);
        check("R8", "clear all", v, 0);

        // R10 identification window
        for (int k = 0; k < 8; k++) begin
            do_read(1'b0, 10'h3F8 + k[9:0], v, e);
            check("R10", "id base", v, {24'b0, id_a[k]});
            do_read(1'b1, 10'h3F8 + k[9:0], v, e);
            check("R10", "id alt", v, {24'b0, id_b[k]});
        end

        // R11 read decode sweep
        for (int w = 0; w < 1024; w++) begin
            logic exp_e;
            exp_e = !((w <= 9) || (w == 11) || (w == 12) || (w >= 'h3F8));
            do_read(1'b0, w[9:0], v, e);
            check("R11", "read err", {31'b0, e}, {31'b0, exp_e});
            if (exp_e) check("R11", "err rdata", v, 0);
        end
        // R11 rejected writes leave state alone
        foreach (id_a[i]) begin
            logic [9:0] a;
            a = (i == 0) ? 10'd8 : (i == 1) ? 10'd9 : (i == 2) ? 10'd11 :
                (i == 3) ? 10'd12 : (i == 4) ? 10'd13 : (i == 5) ? 10'h1FF :
                (i == 6) ? 10'h3F8 : 10'h3FF;
            do_write(1'b0, a, 32'hFFFF_FFFF, e, inv);
            check("R11", "write err", {31'b0, e}, 1);
            check("R12", "inval on bad write", {31'b0, inv}, 1);
        end
        do_read(1'b0, 10'd0, v, e);
        check("R11", "timing0 kept", v, t0_last);
        do_read(1'b0, 10'd4, v, e);
        check("R11", "upbase kept", v, pat[4]);
        do_read(1'b0, 10'd8, v, e);
        check("R11", "status kept", v, 0);
        do_read(1'b0, 10'd6, v, e);
        check("R11", "mask kept", v, 32'h15);
        do_read(1'b0, 10'd10, v, e);
        check("R11", "clear word unreadable", {31'b0, e}, 1);
        @(negedge clk);
        check("R12", "pulse one cycle", {31'b0, inv0}, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule